// File: doc/BRIEF.md
# Quadrature-Sample Event Phase Timestamper

This block turns one pair of signed samples, taken from a sine and a cosine reference at the instant an event arrives, into a fine timestamp. Each sample is first scaled by its own channel gain. The cosine channel is then corrected for a sine/cosine pair that is not exactly 90 degrees apart. The angle of the corrected pair is found over the full circle, because the signs of the two values select the quadrant. That angle becomes an 11-bit fraction of one reference period. With a 200 MHz reference, one count is about 2.5 ps.

The fine phase is joined to a 32-bit free-running count of reference periods, which gives one timestamp. The angle is computed by one shared vectoring CORDIC stage that runs 14 times. While a conversion is in progress, the block cannot take a new strobe. Any strobe that arrives during that time is discarded, and a sticky flag records the loss.

Top module: `qpt_timestamper`

## Requirements
- R1: After reset, `ts_valid_o`, `overrun_o` and `ts_o` are all zero.
- R2: `ts_o[10:0]` holds the event phase P = atan2(S, C) mapped onto 0..2047 for 0..360 degrees. The quadrant comes from the signs of S and C. P is within 2 counts of the exact value, with the error measured modulo 2048.
- R3: The sine sample is normalized as S = sin_i·gain_sin_i/1024. The cosine sample is normalized as Cg = cos_i·gain_cos_i/1024. Both gains are unsigned, with 10 fraction bits.
- R4: The quadrature term is applied as C = Cg − quad_k_i·S/1024. `quad_k_i` is two's complement with 10 fraction bits.
- R5: `ts_o[42:11]` holds the reference-period counter value at the accepting clock edge. The counter is 0 out of reset and counts up by one on every clock.
- R6: `ts_valid_o` goes high for exactly one cycle. It is visible after the 16th rising edge that follows the edge that accepted the strobe.
- R7: A strobe seen on edges 1 to 16 after an accepted strobe is dropped. It produces no result and does not change the pending result.
- R8: A dropped strobe sets `overrun_o`, which stays set until reset.
- R9: A strobe on the 17th edge after an accepted strobe is accepted, and `overrun_o` is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-period clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_i | input | 1 | Event capture strobe |
| sin_i | input | 10 | Signed sine-channel sample |
| cos_i | input | 10 | Signed cosine-channel sample |
| gain_sin_i | input | 12 | Sine gain, unsigned, 10 fraction bits |
| gain_cos_i | input | 12 | Cosine gain, unsigned, 10 fraction bits |
| quad_k_i | input | 12 | Quadrature correction, signed, 10 fraction bits |
| ts_valid_o | output | 1 | One-cycle result strobe |
| ts_o | output | 43 | {period count, phase} |
| overrun_o | output | 1 | Sticky dropped-strobe flag |

## Verification
A wrong quadrant choice shows up in the next result as a phase that is about 1024 counts off. A bad angle table or a bad shift gives a phase error in every result. A stuck or miscounted iteration counter moves `ts_valid_o` away from its fixed 16-edge latency, or stops it altogether, so the very first conversion exposes it. A wrong busy window shows within a single cycle: a strobe at the 17th edge either raises `overrun_o` when it should not, or an early strobe replaces the captured sample and changes the period field of the next timestamp.

// File: rtl/qpt_pkg.sv
package qpt_pkg;

    localparam int unsigned ANG_W = 16;

    typedef enum logic [1:0] {
        CS_IDLE = 2'd0,
        CS_ITER = 2'd1,
        CS_FIN  = 2'd2
    } cordic_st_e;

    // arctan(2^-i) with the full circle scaled to 2^16
    function automatic int unsigned atan_step(input int unsigned i);
        case (i)
            0:  return 8192;
            1:  return 4836;
            2:  return 2555;
            3:  return 1297;
            4:  return 651;
            5:  return 326;
            6:  return 163;
            7:  return 81;
            8:  return 41;
            9:  return 20;
            10: return 10;
            11: return 5;
            12: return 3;
            13: return 1;
            14: return 1;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/qpt_calib.sv
module qpt_calib #(
    parameter int SW    = 10,
    parameter int GW    = 12,
    parameter int KW    = 12,
    parameter int FRAC  = 10,
    parameter int W     = 20,
    parameter int GUARD = 4
) (
    input  logic signed [SW-1:0] s_i,
    input  logic signed [SW-1:0] c_i,
    input  logic        [GW-1:0] gs_i,
    input  logic        [GW-1:0] gc_i,
    input  logic signed [KW-1:0] k_i,
    output logic signed [W-1:0]  x_o,
    output logic signed [W-1:0]  y_o,
    output logic                 half_o
);
    localparam int PW = SW + GW + 1;
    localparam int QW = PW + KW;

    logic signed [PW-1:0] s_p, c_p, s_g, c_g;
    logic signed [QW-1:0] ks_p;
    logic signed [W-1:0]  s_n, c_n, s_sc, c_sc;

    always_comb begin
        // per-channel amplitude normalization (R3)
        s_p  = PW'(s_i) * PW'($signed({1'b0, gs_i}));
        c_p  = PW'(c_i) * PW'($signed({1'b0, gc_i}));
        s_g  = s_p >>> FRAC;
        c_g  = c_p >>> FRAC;
        // quadrature skew correction on the cosine channel (R4)
        ks_p = QW'(s_g) * QW'(k_i);
        s_n  = W'(s_g);
        c_n  = W'(c_g) - W'(ks_p >>> FRAC);
        s_sc = s_n <<< GUARD;
        c_sc = c_n <<< GUARD;
        // fold the left half-plane onto the right one (R2)
        half_o = c_sc[W-1];
        x_o    = half_o ? -c_sc : c_sc;
        y_o    = half_o ? -s_sc : s_sc;
    end
endmodule

// File: rtl/qpt_cordic.sv
module qpt_cordic
    import qpt_pkg::*;
#(
    parameter int W     = 20,
    parameter int ITERS = 14,
    parameter int PH_W  = 11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic signed [W-1:0] x_i,
    input  logic signed [W-1:0] y_i,
    input  logic                half_i,
    output logic                busy_o,
    output logic                done_o,
    output logic [PH_W-1:0]     phase_o
);
    localparam int IT_W = $clog2(ITERS) + 1;
    localparam int SH   = ANG_W - PH_W;

    typedef struct packed {
        cordic_st_e         st;
        logic [IT_W-1:0]    it;
        logic signed [W-1:0] x;
        logic signed [W-1:0] y;
        logic [ANG_W-1:0]   z;
    } core_s;

    core_s r_d, r_q;
    logic [ANG_W-1:0] step;
    logic [ANG_W-1:0] rnd;

    always_comb begin
        r_d  = r_q;
        step = ANG_W'(atan_step(32'(r_q.it)));
        case (r_q.st)
            CS_IDLE: begin
                if (start_i) begin
                    r_d.x  = x_i;
                    r_d.y  = y_i;
                    r_d.z  = half_i ? ANG_W'(1 << (ANG_W - 1)) : '0;
                    r_d.it = '0;
                    r_d.st = CS_ITER;
                end
            end
            CS_ITER: begin
                if (!r_q.y[W-1]) begin
                    r_d.x = r_q.x + (r_q.y >>> r_q.it);
                    r_d.y = r_q.y - (r_q.x >>> r_q.it);
                    r_d.z = r_q.z + step;
                end else begin
                    r_d.x = r_q.x - (r_q.y >>> r_q.it);
                    r_d.y = r_q.y + (r_q.x >>> r_q.it);
                    r_d.z = r_q.z - step;
                end
                r_d.it = r_q.it + 1'b1;
                if (r_q.it == IT_W'(ITERS - 1)) r_d.st = CS_FIN;
            end
            default: r_d.st = CS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rnd     = r_q.z + ANG_W'(1 << (SH - 1));
    assign phase_o = PH_W'(rnd >> SH);
    assign busy_o  = (r_q.st != CS_IDLE);
    assign done_o  = (r_q.st == CS_FIN);

    // R6: iteration index never passes the configured count
    a_r6_iter_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == CS_ITER) |-> (r_q.it < IT_W'(ITERS)));
    // R7: the core is only started when idle
    a_r7_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !busy_o);
    // R6: completion is a single-cycle event
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
endmodule

// File: rtl/qpt_timestamper.sv
module qpt_timestamper #(
    parameter int SW    = 10,
    parameter int GW    = 12,
    parameter int KW    = 12,
    parameter int CW    = 32,
    parameter int PH_W  = 11,
    parameter int ITERS = 14
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cap_i,
    input  logic signed [SW-1:0] sin_i,
    input  logic signed [SW-1:0] cos_i,
    input  logic        [GW-1:0] gain_sin_i,
    input  logic        [GW-1:0] gain_cos_i,
    input  logic signed [KW-1:0] quad_k_i,
    output logic                 ts_valid_o,
    output logic [CW+PH_W-1:0]   ts_o,
    output logic                 overrun_o
);
    localparam int FRAC  = 10;
    localparam int GUARD = 4;
    localparam int W     = SW + GUARD + 6;
    localparam int TS_W  = CW + PH_W;

    typedef struct packed {
        logic [CW-1:0]   cnt;
        logic [CW-1:0]   cnt_cap;
        logic signed [SW-1:0] s;
        logic signed [SW-1:0] c;
        logic            pend;
        logic            ovr;
        logic            vld;
        logic [TS_W-1:0] ts;
    } top_s;

    top_s r_d, r_q;

    logic                core_busy, core_done, busy, half;
    logic [PH_W-1:0]     core_phase;
    logic signed [W-1:0] x0, y0;

    assign busy = r_q.pend | core_busy;

    qpt_calib #(.SW(SW), .GW(GW), .KW(KW), .FRAC(FRAC), .W(W), .GUARD(GUARD)) calib_i (
        .s_i(r_q.s), .c_i(r_q.c), .gs_i(gain_sin_i), .gc_i(gain_cos_i), .k_i(quad_k_i),
        .x_o(x0), .y_o(y0), .half_o(half)
    );

    qpt_cordic #(.W(W), .ITERS(ITERS), .PH_W(PH_W)) core_i (
        .clk(clk), .rst_n(rst_n), .start_i(r_q.pend), .x_i(x0), .y_i(y0), .half_i(half),
        .busy_o(core_busy), .done_o(core_done), .phase_o(core_phase)
    );

    always_comb begin
        r_d      = r_q;
        r_d.cnt  = r_q.cnt + CW'(1);
        r_d.vld  = 1'b0;
        r_d.pend = 1'b0;
        if (cap_i && !busy) begin
            r_d.s       = sin_i;
            r_d.c       = cos_i;
            r_d.cnt_cap = r_q.cnt;
            r_d.pend    = 1'b1;
        end
        if (cap_i && busy) r_d.ovr = 1'b1;
        if (core_done) begin
            r_d.vld = 1'b1;
            r_d.ts  = {r_q.cnt_cap, core_phase};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ts_valid_o = r_q.vld;
    assign ts_o       = r_q.ts;
    assign overrun_o  = r_q.ovr;

    // R8: a strobe during a conversion raises the flag
    a_r8_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_i && busy) |=> overrun_o);
    // R8: the flag is sticky
    a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_o |=> overrun_o);
    // R6: core completion produces the result strobe next cycle
    a_r6_done_to_valid: assert property (@(posedge clk) disable iff (!rst_n)
        core_done |=> ts_valid_o);
    // R6: one-cycle result strobe
    a_r6_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        ts_valid_o |=> !ts_valid_o);
    // R9: an accepted strobe makes the block busy
    a_r9_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_i && !busy) |=> busy);
endmodule

// File: tb/qpt_timestamper_tb_top.sv
`timescale 1ns/1ps
module qpt_timestamper_tb_top;
    localparam real PI = 3.14159265358979;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cap_i = 1'b0;
    logic signed [9:0]  sin_i = '0, cos_i = '0;
    logic [11:0]        gain_sin_i = 12'd1024, gain_cos_i = 12'd1024;
    logic signed [11:0] quad_k_i = '0;
    logic               ts_valid_o, overrun_o;
    logic [42:0]        ts_o;

    int unsigned cyc = 0;
    int          checks = 0, fails = 0, results = 0, pushes = 0;
    bit          prev_vld = 1'b0;

    int unsigned q_cnt[$];
    real         q_ph[$];
    string       q_tag[$];

    always #2.5 clk = ~clk;

    qpt_timestamper dut_i (
        .clk(clk), .rst_n(rst_n), .cap_i(cap_i), .sin_i(sin_i), .cos_i(cos_i),
        .gain_sin_i(gain_sin_i), .gain_cos_i(gain_cos_i), .quad_k_i(quad_k_i),
        .ts_valid_o(ts_valid_o), .ts_o(ts_o), .overrun_o(overrun_o)
    );

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // expected phase in counts, following R2..R4
    function automatic real exp_phase(input int s, input int c, input int gs,
                                      input int gc, input int k);
        real sn, cn, a;
        sn = s * gs / 1024.0;
        cn = c * gc / 1024.0 - k * sn / 1024.0;
        a  = $atan2(sn, cn);
        if (a < 0.0) a = a + 2.0 * PI;
        return a * 2048.0 / (2.0 * PI);
    endfunction

    // caller sits at a negedge; the next posedge accepts the strobe
    task automatic send(input int s, input int c, input int gs, input int gc,
                        input int k, input string tag);
        sin_i = 10'(s); cos_i = 10'(c);
        gain_sin_i = 12'(gs); gain_cos_i = 12'(gc); quad_k_i = 12'(k);
        cap_i = 1'b1;
        q_cnt.push_back(cyc);
        q_ph.push_back(exp_phase(s, c, gs, gc, k));
        q_tag.push_back(tag);
        pushes++;
        @(negedge clk);
        cap_i = 1'b0;
    endtask

    task automatic send_ang(input real deg, input int as, input int ac,
                            input int gs, input int gc, input int k, input string tag);
        real th;
        th = deg * PI / 180.0;
        send(int'(as * $sin(th)), int'(ac * $cos(th)), gs, gc, k, tag);
        repeat (20) @(negedge clk);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_vld && ts_valid_o)
                check(1'b0, "R6", "valid longer than one cycle", 2, 1);
            if (ts_valid_o) begin
                results++;
                if (q_cnt.size() == 0) begin
                    check(1'b0, "R7", "unexpected result", results, pushes);
                end else begin
                    int unsigned ec;
                    real         ep, d;
                    string       tg;
                    ec = q_cnt.pop_front();
                    ep = q_ph.pop_front();
                    tg = q_tag.pop_front();
                    d  = real'(ts_o[10:0]) - ep;
                    while (d > 1024.0)  d = d - 2048.0;
                    while (d < -1024.0) d = d + 2048.0;
                    check(d <= 2.0 && d >= -2.0, tg, "phase",
                          longint'(ts_o[10:0]), longint'($rtoi(ep + 0.5)) % 2048);
                    check(ts_o[42:11] == ec, "R5", "period count",
                          longint'(ts_o[42:11]), longint'(ec));
                    check(cyc - ec == 17, "R6", "latency (cycles+1)",
                          longint'(cyc - ec), 17);
                end
            end
            prev_vld <= ts_valid_o;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(ts_valid_o == 1'b0, "R1", "reset valid", ts_valid_o, 0);
        check(overrun_o == 1'b0, "R1", "reset overrun", overrun_o, 0);
        check(ts_o == '0, "R1", "reset timestamp", longint'(ts_o), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R2: full circle, unity gains, no skew
        send_ang(0.0,   400, 400, 1024, 1024, 0, "R2");
        send_ang(30.0,  400, 400, 1024, 1024, 0, "R2");
        send_ang(90.0,  400, 400, 1024, 1024, 0, "R2");
        send_ang(135.0, 400, 400, 1024, 1024, 0, "R2");
        send_ang(180.0, 400, 400, 1024, 1024, 0, "R2");
        send_ang(225.0, 400, 400, 1024, 1024, 0, "R2");
        send_ang(270.0, 400, 400, 1024, 1024, 0, "R2");
        send_ang(300.0, 400, 400, 1024, 1024, 0, "R2");
        send_ang(359.5, 400, 400, 1024, 1024, 0, "R2");
        // R3: unequal channel amplitudes compensated by gains
        send_ang(60.0,  250, 400, 1638, 1024, 0, "R3");
        send_ang(160.0, 400, 220, 1024, 1862, 0, "R3");
        // R4: quadrature skew correction, both signs
        send_ang(45.0,  400, 400, 1024, 1024, 102, "R4");
        send_ang(250.0, 400, 400, 1024, 1024, -205, "R4");
        send_ang(200.0, 300, 350, 1365, 1170, 60, "R4");

        check(overrun_o == 1'b0, "R8", "no overrun after spaced traffic", overrun_o, 0);

        // R9: back-to-back at the 17th edge
        send(200, 300, 1024, 1024, 0, "R9");
        repeat (16) @(negedge clk);
        send(-310, 120, 1024, 1024, 0, "R9");
        repeat (20) @(negedge clk);
        check(overrun_o == 1'b0, "R9", "17-edge spacing accepted", overrun_o, 0);
        check(results == pushes, "R9", "result count", results, pushes);

        // R7/R8: strobe during a conversion is dropped
        send(-150, -350, 1024, 1024, 0, "R7");
        repeat (4) @(negedge clk);
        sin_i = 10'sd300; cos_i = 10'sd10; cap_i = 1'b1;
        @(negedge clk);
        cap_i = 1'b0;
        check(overrun_o == 1'b1, "R8", "overrun set by dropped strobe", overrun_o, 1);
        repeat (25) @(negedge clk);
        check(results == pushes, "R7", "dropped strobe makes no result", results, pushes);
        check(overrun_o == 1'b1, "R8", "overrun stays set", overrun_o, 1);
        send_ang(100.0, 400, 400, 1024, 1024, 0, "R2");
        check(overrun_o == 1'b1, "R8", "overrun sticky after new result", overrun_o, 1);
        check(q_cnt.size() == 0, "R7", "scoreboard drained", q_cnt.size(), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R6 watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule